// File: doc/BRIEF.md
# Parallel FIFO Bus Master

This block lets on-chip logic talk to an external asynchronous byte-wide FIFO device. The device shows two active-low status flags: a space flag (low while it can take a byte) and an available flag (low while it holds a byte for the host). Transfers use an active-high write strobe, an active-low read strobe and a shared 8-bit data bus. Inside the chip the bus is split into an output byte, an output enable and an input byte, and these meet at the pad. Bytes to send arrive on a valid/ready stream. Bytes read back leave on a second valid/ready stream.

The device latches a write on the falling edge of the write strobe. It drives the bus while the read strobe is low, with data valid no more than 50 ns after that strobe falls. Each flag changes state only after a strobe, so the master makes every transfer wait for a flag that it has sampled afresh. Flags pass through a synchroniser. After every strobe there is a recovery window, so that a flag already changed by that strobe is never acted on while its old value is still in the synchroniser. The widths of the setup time, both strobe pulses and the recovery window are parameters counted in clock periods. The defaults suit a 4 ns clock: the 13-cycle read pulse covers the 50 ns access time. When both directions are ready in the same idle cycle, the master alternates between them.

Top module: `pfifo_host`

## Requirements
- R1: A write cycle starts only when the synchronised space flag is low (0 = device can accept). `tx_ready_o` is high only in the idle cycle in which that write is granted. While the flag is high, no write strobe appears and no byte is taken.
- R2: A read cycle starts only when the synchronised available flag is low (0 = device holds data) and the output stream register is empty. While the flag is high, the read strobe stays high.
- R3: In a write cycle, `dev_dq_oe_o` goes high at least SETUP_CYC cycles before `dev_wr_o` rises. `dev_wr_o` stays high for exactly WR_PULSE_CYC cycles. The byte and the enable are held for one further cycle after the strobe falls. The byte on `dev_dq_o` is the one accepted from the stream.
- R4: In a read cycle, `dev_dq_oe_o` stays low and `dev_rd_n_o` is low for exactly RD_PULSE_CYC cycles. `dev_dq_i` is captured on the last low cycle and appears on `rx_data_o` with `rx_valid_o` as the strobe returns high.
- R5: After any strobe returns to its inactive level, both strobes stay inactive for at least RECOVER_CYC+1 cycles. The next transfer decision uses flags sampled after the strobe ended, so a flag raised by the device after a strobe holds off the next transfer until it drops again.
- R6: When a write and a read are both eligible in the same idle cycle, the direction opposite to the last transfer is chosen. After reset, write wins.
- R7: While `rx_valid_o` is high and `rx_ready_i` is low, `rx_valid_o` and `rx_data_o` hold and no further read is started.
- R8: During reset, `dev_wr_o`=0, `dev_rd_n_o`=1, `dev_dq_oe_o`=0, `rx_valid_o`=0 and `tx_ready_o`=0.
- R9: Bytes leave the device write side and the read stream in the order in which they were offered, with no loss or duplication.
- R10: Each flag passes through SYNC_STAGES flops that reset to the inactive level. When the space flag falls while a byte waits in idle, `tx_ready_o` rises SYNC_STAGES cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 8 | Byte to write to the device |
| tx_valid_i | input | 1 | Byte offered |
| tx_ready_o | output | 1 | Byte taken this cycle |
| rx_data_o | output | 8 | Byte read from the device |
| rx_valid_o | output | 1 | Read byte present |
| rx_ready_i | input | 1 | Consumer takes the read byte |
| dev_space_n_i | input | 1 | Device space flag, low = can accept a byte |
| dev_avail_n_i | input | 1 | Device available flag, low = holds a byte |
| dev_wr_o | output | 1 | Write strobe, device latches on its falling edge |
| dev_rd_n_o | output | 1 | Read strobe, active low, enables device drivers |
| dev_dq_o | output | 8 | Bus value driven by the master |
| dev_dq_oe_o | output | 1 | Bus output enable |
| dev_dq_i | input | 8 | Bus value seen at the pad |

## Verification
A pending outgoing byte and a non-empty device receive side can both be ready in the same idle cycle. The arbiter must then pick one direction, and this is the case that decides fairness. The bench queues all read bytes in the device model before it offers the first write byte. It keeps the space flag busy for only one cycle after each write and holds the read stream ready, so that every idle decision sees both requests. The log of strobe starts must then read write, read, write, read across the whole burst, and both data streams must come out complete and in order.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_RPULSE,
        ST_RECOV
    } phase_e;

    typedef enum logic [1:0] {
        GR_NONE,
        GR_WR,
        GR_RD
    } grant_e;

endpackage

// File: rtl/pfifo_flag_sync.sv
module pfifo_flag_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    // Each stage samples the one before it; stage 0 samples the pad.
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stage_d[g] = async_i;
        end else begin : g_next
            assign stage_d[g] = stage_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pfifo_arb.sv
module pfifo_arb
    import pfifo_pkg::*;
(
    input  logic   want_wr_i,
    input  logic   want_rd_i,
    input  logic   prefer_rd_i,
    output grant_e grant_o
);

    always_comb begin
        if (want_wr_i && want_rd_i) begin
            grant_o = prefer_rd_i ? GR_RD : GR_WR;
        end else if (want_wr_i) begin
            grant_o = GR_WR;
        end else if (want_rd_i) begin
            grant_o = GR_RD;
        end else begin
            grant_o = GR_NONE;
        end
    end

endmodule

// File: rtl/pfifo_seq.sv
module pfifo_seq
    import pfifo_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SETUP_CYC    = 2,
    parameter int WR_PULSE_CYC = 5,
    parameter int RD_PULSE_CYC = 13,
    parameter int RECOVER_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  grant_e        grant_i,
    input  logic          space_ok_i,
    input  logic          avail_ok_i,
    input  logic [DW-1:0] tx_data_i,
    output logic          tx_ready_o,
    input  logic          rx_ready_i,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_valid_o,
    output logic          rx_room_o,
    output logic          prefer_rd_o,
    output logic          wr_o,
    output logic          rd_n_o,
    output logic          oe_o,
    output logic [DW-1:0] dout_o,
    input  logic [DW-1:0] din_i
);

    localparam int MAX_A = (SETUP_CYC > WR_PULSE_CYC) ? SETUP_CYC : WR_PULSE_CYC;
    localparam int MAX_B = (RD_PULSE_CYC > RECOVER_CYC) ? RD_PULSE_CYC : RECOVER_CYC;
    localparam int MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_P + 1);

    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] WR_LAST    = CW'(WR_PULSE_CYC - 1);
    localparam logic [CW-1:0] RD_LAST    = CW'(RD_PULSE_CYC - 1);
    localparam logic [CW-1:0] REC_LAST   = CW'(RECOVER_CYC - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          wr;
        logic          rd_n;
        logic          oe;
        logic [DW-1:0] dout;
        logic [DW-1:0] rxd;
        logic          rxv;
        logic          last_wr;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase:   ST_IDLE,
        cnt:     '0,
        wr:      1'b0,
        rd_n:    1'b1,
        oe:      1'b0,
        dout:    '0,
        rxd:     '0,
        rxv:     1'b0,
        last_wr: 1'b0
    };

    seq_t q, d;

    always_comb begin
        d          = q;
        tx_ready_o = 1'b0;

        if (q.rxv && rx_ready_i) d.rxv = 1'b0;

        case (q.phase)
            ST_IDLE: begin
                if (grant_i == GR_WR) begin
                    tx_ready_o = 1'b1;
                    d.dout     = tx_data_i;
                    d.oe       = 1'b1;
                    d.cnt      = '0;
                    d.last_wr  = 1'b1;
                    d.phase    = ST_WSETUP;
                end else if (grant_i == GR_RD) begin
                    d.rd_n    = 1'b0;
                    d.cnt     = '0;
                    d.last_wr = 1'b0;
                    d.phase   = ST_RPULSE;
                end
            end
            ST_WSETUP: begin
                if (q.cnt == SETUP_LAST) begin
                    d.wr    = 1'b1;
                    d.cnt   = '0;
                    d.phase = ST_WPULSE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WPULSE: begin
                if (q.cnt == WR_LAST) begin
                    d.wr    = 1'b0;
                    d.cnt   = '0;
                    d.phase = ST_RECOV;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RPULSE: begin
                if (q.cnt == RD_LAST) begin
                    d.rd_n  = 1'b1;
                    d.rxd   = din_i;
                    d.rxv   = 1'b1;
                    d.cnt   = '0;
                    d.phase = ST_RECOV;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RECOV: begin
                // bus stays driven for the first recovery cycle as hold time
                d.oe = 1'b0;
                if (q.cnt == REC_LAST) begin
                    d.cnt   = '0;
                    d.phase = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: begin
                d = SEQ_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign rx_data_o   = q.rxd;
    assign rx_valid_o  = q.rxv;
    assign rx_room_o   = !q.rxv;
    assign prefer_rd_o = q.last_wr;
    assign wr_o        = q.wr;
    assign rd_n_o      = q.rd_n;
    assign oe_o        = q.oe;
    assign dout_o      = q.dout;

    // R1: a granted write needs the synchronised space flag
    a_r1_write_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE && grant_i == GR_WR) |-> space_ok_i);

    // R2: a granted read needs the available flag and an empty output register
    a_r2_read_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_IDLE && grant_i == GR_RD) |-> (avail_ok_i && !q.rxv));

    // R3: bus driven whenever the write strobe is high
    a_r3_bus_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> q.oe);

    // R3: bus still driven in the cycle after the strobe falls
    a_r3_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.wr) |-> q.oe);

    // R3: driven byte does not change while the bus stays enabled
    a_r3_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe && $past(q.oe)) |-> $stable(q.dout));

    // R4: bus released during a read
    a_r4_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rd_n |-> !q.oe);

    // R4: read byte appears exactly as the read strobe ends
    a_r4_capture_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rxv) |-> $rose(q.rd_n));

    // R5: never both strobes active
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.wr && !q.rd_n));

    // R7: held output under back-pressure
    a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rxv && !rx_ready_i) |=> (q.rxv && $stable(q.rxd)));

endmodule

// File: rtl/pfifo_host.sv
module pfifo_host
    import pfifo_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int SETUP_CYC    = 2,
    parameter int WR_PULSE_CYC = 5,
    parameter int RD_PULSE_CYC = 13,
    parameter int RECOVER_CYC  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tx_data_i,
    input  logic          tx_valid_i,
    output logic          tx_ready_o,
    output logic [DW-1:0] rx_data_o,
    output logic          rx_valid_o,
    input  logic          rx_ready_i,
    input  logic          dev_space_n_i,
    input  logic          dev_avail_n_i,
    output logic          dev_wr_o,
    output logic          dev_rd_n_o,
    output logic [DW-1:0] dev_dq_o,
    output logic          dev_dq_oe_o,
    input  logic [DW-1:0] dev_dq_i
);

    localparam int NFLAG = 2;

    logic [NFLAG-1:0] flag_s;
    logic             space_ok, avail_ok;
    logic             rx_room, prefer_rd;
    grant_e           grant;

    pfifo_flag_sync #(
        .WIDTH   (NFLAG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NFLAG{1'b1}})
    ) flag_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dev_avail_n_i, dev_space_n_i}),
        .sync_o  (flag_s)
    );

    assign space_ok = !flag_s[0];
    assign avail_ok = !flag_s[1];

    pfifo_arb arb_i (
        .want_wr_i   (tx_valid_i && space_ok),
        .want_rd_i   (avail_ok && rx_room),
        .prefer_rd_i (prefer_rd),
        .grant_o     (grant)
    );

    pfifo_seq #(
        .DW           (DW),
        .SETUP_CYC    (SETUP_CYC),
        .WR_PULSE_CYC (WR_PULSE_CYC),
        .RD_PULSE_CYC (RD_PULSE_CYC),
        .RECOVER_CYC  (RECOVER_CYC)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant),
        .space_ok_i  (space_ok),
        .avail_ok_i  (avail_ok),
        .tx_data_i   (tx_data_i),
        .tx_ready_o  (tx_ready_o),
        .rx_ready_i  (rx_ready_i),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o),
        .rx_room_o   (rx_room),
        .prefer_rd_o (prefer_rd),
        .wr_o        (dev_wr_o),
        .rd_n_o      (dev_rd_n_o),
        .oe_o        (dev_dq_oe_o),
        .dout_o      (dev_dq_o),
        .din_i       (dev_dq_i)
    );

endmodule

// File: tb/pfifo_host_tb_top.sv
`timescale 1ns/1ps
module pfifo_host_tb_top;

    localparam int SETUP   = 2;
    localparam int WRP     = 5;
    localparam int RDP     = 13;
    localparam int REC     = 4;
    localparam int SYNC    = 2;
    localparam int ACC_CYC = 12;   // 48 ns access at 4 ns per cycle
    localparam int NV      = 8;

    typedef struct packed {
        logic [7:0] wb;
        logic [7:0] rb;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{wb: 8'h00, rb: 8'hFF},
        '{wb: 8'hFF, rb: 8'h00},
        '{wb: 8'h55, rb: 8'hAA},
        '{wb: 8'hAA, rb: 8'h55},
        '{wb: 8'h01, rb: 8'h80},
        '{wb: 8'h80, rb: 8'h01},
        '{wb: 8'h7E, rb: 8'hC3},
        '{wb: 8'h3C, rb: 8'h96}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b1;
    logic       dev_space_n, dev_avail_n;
    logic       dev_wr, dev_rd_n, dq_oe;
    logic [7:0] dq_o;
    logic [7:0] dq_i = 8'hEE;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    bit tx_block = 1'b0;
    bit rx_block = 1'b0;
    int dev_busy = 1;
    int tx_busy  = 0;

    logic [7:0] rxq[$];
    logic [7:0] wr_got[$];
    logic [7:0] rx_got[$];
    bit         ops[$];        // 1 = write strobe start, 0 = read strobe start
    int         wr_rise_cyc[$];
    int         wr_fall_cyc[$];
    int         rd_falls = 0;

    assign dev_space_n = tx_block | (tx_busy != 0);
    assign dev_avail_n = rx_block | (rxq.size() == 0);

    always #2 clk = ~clk;

    pfifo_host #(
        .DW(8), .SYNC_STAGES(SYNC), .SETUP_CYC(SETUP),
        .WR_PULSE_CYC(WRP), .RD_PULSE_CYC(RDP), .RECOVER_CYC(REC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
        .dev_space_n_i(dev_space_n), .dev_avail_n_i(dev_avail_n),
        .dev_wr_o(dev_wr), .dev_rd_n_o(dev_rd_n),
        .dev_dq_o(dq_o), .dev_dq_oe_o(dq_oe), .dev_dq_i(dq_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device model and protocol monitor, all at the falling clock edge.
    logic wr_p = 1'b0, rd_p = 1'b1;
    int   wr_len = 0, rd_len = 0, oe_run = 0, idle_run = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_busy > 0) tx_busy--;
            if (dev_wr && !wr_p) begin
                chk(dev_space_n == 1'b0, "R1 write while space flag high", dev_space_n, 0);
                chk(oe_run >= SETUP, "R3 setup before strobe", oe_run, SETUP);
                chk(idle_run >= REC + 1, "R5 gap before write", idle_run, REC + 1);
                ops.push_back(1'b1);
                wr_rise_cyc.push_back(cyc);
                wr_len = 0;
            end
            if (!dev_rd_n && rd_p) begin
                chk(dev_avail_n == 1'b0, "R2 read while avail flag high", dev_avail_n, 0);
                chk(dq_oe == 1'b0, "R4 bus released in read", dq_oe, 0);
                chk(idle_run >= REC + 1, "R5 gap before read", idle_run, REC + 1);
                ops.push_back(1'b0);
                rd_len = 0;
                rd_falls++;
            end
            if (dev_wr) wr_len++;
            if (!dev_rd_n) rd_len++;
            if (!dev_wr && wr_p) begin
                chk(wr_len == WRP, "R3 write pulse width", wr_len, WRP);
                chk(dq_oe == 1'b1, "R3 hold after strobe", dq_oe, 1);
                wr_got.push_back(dq_o);
                wr_fall_cyc.push_back(cyc);
                tx_busy = dev_busy;
            end
            if (dev_rd_n && !rd_p) begin
                chk(rd_len == RDP, "R4 read pulse width", rd_len, RDP);
                if (rxq.size() > 0) void'(rxq.pop_front());
            end
            dq_i = (!dev_rd_n && rd_len >= ACC_CYC && rxq.size() > 0) ? rxq[0] : 8'hEE;
            if (rx_valid && rx_ready) rx_got.push_back(rx_data);
            oe_run   = dq_oe ? oe_run + 1 : 0;
            idle_run = (!dev_wr && dev_rd_n) ? idle_run + 1 : 0;
            wr_p = dev_wr;
            rd_p = dev_rd_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Called at a falling edge; returns at a falling edge after the handshake.
    task automatic send(input logic [7:0] b);
        bit taken = 1'b0;
        tx_data  = b;
        tx_valid = 1'b1;
        while (!taken) begin
            #1;
            if (tx_ready) taken = 1'b1;
            else @(negedge clk);
        end
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_sizes(input int nw, input int nr);
        for (int k = 0; k < 20000 && (wr_got.size() < nw || rx_got.size() < nr); k++)
            @(negedge clk);
    endtask

    initial begin
        int lat;
        bit saw_ready;
        int base;

        tx_block = 1'b1;
        repeat (4) @(negedge clk);
        // R8 reset values
        chk(dev_wr == 1'b0, "R8 write strobe in reset", dev_wr, 0);
        chk(dev_rd_n == 1'b1, "R8 read strobe in reset", dev_rd_n, 1);
        chk(dq_oe == 1'b0, "R8 bus enable in reset", dq_oe, 0);
        chk(rx_valid == 1'b0, "R8 rx_valid in reset", rx_valid, 0);
        chk(tx_ready == 1'b0, "R8 tx_ready in reset", tx_ready, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: byte offered while device full is not taken
        tx_data  = 8'hA5;
        tx_valid = 1'b1;
        saw_ready = 1'b0;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (tx_ready) saw_ready = 1'b1;
            @(negedge clk);
        end
        chk(saw_ready == 1'b0, "R1 tx_ready while space flag high", saw_ready, 0);
        chk(ops.size() == 0, "R1 strobes while space flag high", ops.size(), 0);

        // R10: latency from flag release to tx_ready
        tx_block = 1'b0;
        lat = 0;
        #1;
        while (!tx_ready && lat < 50) begin
            @(negedge clk);
            #1;
            lat++;
        end
        chk(lat == SYNC, "R10 flag synchroniser latency", lat, SYNC);
        @(negedge clk);
        tx_valid = 1'b0;
        wait_sizes(1, 0);
        chk(wr_got.size() == 1 && wr_got[0] == 8'hA5, "R3 written byte", wr_got.size() > 0 ? wr_got[0] : -1, 8'hA5);

        // R2: device data hidden by a high avail flag is not read
        repeat (10) @(negedge clk);
        rx_block = 1'b1;
        base = rd_falls;
        rxq.push_back(8'h3C);
        repeat (40) @(negedge clk);
        chk(rd_falls == base, "R2 read while avail flag high", rd_falls - base, 0);
        chk(rx_valid == 1'b0, "R2 rx_valid while blocked", rx_valid, 0);
        rx_block = 1'b0;
        wait_sizes(0, 1);
        chk(rx_got.size() == 1 && rx_got[0] == 8'h3C, "R4 read byte", rx_got.size() > 0 ? rx_got[0] : -1, 8'h3C);

        // Vector table: both directions loaded together (R9, R6, R4, R3)
        repeat (10) @(negedge clk);
        wr_got.delete();
        rx_got.delete();
        ops.delete();
        for (int i = 0; i < NV; i++) rxq.push_back(VEC[i].rb);
        for (int i = 0; i < NV; i++) send(VEC[i].wb);
        wait_sizes(NV, NV);
        for (int i = 0; i < NV; i++) begin
            chk(i < wr_got.size() && wr_got[i] == VEC[i].wb, "R9 write order/data",
                i < wr_got.size() ? wr_got[i] : -1, VEC[i].wb);
            chk(i < rx_got.size() && rx_got[i] == VEC[i].rb, "R9 read order/data",
                i < rx_got.size() ? rx_got[i] : -1, VEC[i].rb);
        end
        for (int k = 0; k < 2 * NV; k++) begin
            chk(k < ops.size() && ops[k] == ((k % 2) == 0), "R6 alternation",
                k < ops.size() ? ops[k] : -1, (k % 2) == 0);
        end

        // R7: back-pressure on the read stream
        repeat (10) @(negedge clk);
        rx_got.delete();
        rx_ready = 1'b0;
        base = rd_falls;
        rxq.push_back(8'h11);
        rxq.push_back(8'h22);
        rxq.push_back(8'h33);
        repeat (100) @(negedge clk);
        chk(rx_valid == 1'b1, "R7 rx_valid held", rx_valid, 1);
        chk(rx_data == 8'h11, "R7 rx_data held", rx_data, 8'h11);
        chk(rd_falls - base == 1, "R7 no read while output full", rd_falls - base, 1);
        rx_ready = 1'b1;
        wait_sizes(0, 3);
        chk(rx_got.size() == 3 && rx_got[0] == 8'h11 && rx_got[1] == 8'h22 && rx_got[2] == 8'h33,
            "R7 drained in order", rx_got.size(), 3);

        // R5: flag raised after a write holds off the next write
        repeat (10) @(negedge clk);
        dev_busy = 20;
        wr_got.delete();
        wr_rise_cyc.delete();
        wr_fall_cyc.delete();
        send(8'h5A);
        send(8'hC3);
        wait_sizes(2, 0);
        chk(wr_rise_cyc.size() == 2 && wr_fall_cyc.size() >= 1 &&
            (wr_rise_cyc[1] - wr_fall_cyc[0]) >= 20, "R5 next write waits for flag",
            (wr_rise_cyc.size() == 2) ? wr_rise_cyc[1] - wr_fall_cyc[0] : -1, 20);
        chk(wr_got.size() == 2 && wr_got[1] == 8'hC3, "R9 second byte after hold-off",
            wr_got.size() > 1 ? wr_got[1] : -1, 8'hC3);

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule